// File: doc/BRIEF.md
# Square-Wave Tone Channel with Frequency Sweep

This block produces one voice of a simple sound generator: a square wave whose high time per cycle can be set to one of four duty ratios, whose pitch can glide up or down exponentially, whose loudness follows a linear ramp, and which can stop itself after a programmed duration. Software programs it through a byte-wide write port that selects one of five control registers. A slow timebase tick, at 512 Hz in the intended system, drives the sweep, ramp and duration timers. The output is a 4-bit amplitude sample and a flag that tells whether the voice is still sounding.

The waveform runs at the core clock. A down-counter is reloaded with 2048 minus the 11-bit frequency code and moves the waveform one of eight steps each time it runs out. A write with the restart bit set re-arms every unit. A sweep that would push the frequency code past 2047, or a duration counter that reaches zero while its stop enable is set, silences the voice until the next restart.

Top module: `sq_sweep_voice`

## Requirements
- R1: The duty field (bits 7:6 of register 1) selects how many of the eight waveform steps are high: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 6. The high steps are the last ones of the cycle. While the voice is active the amplitude equals the current volume on high steps and 0 on low steps.
- R2: Each waveform step lasts 2048 minus F core cycles, so the output repeats every 8 times (2048 minus F) cycles. F is the 11-bit frequency code, with bits 7:0 in register 3 and bits 2:0 of register 4 as bits 10:8.
- R3: A write to register 4 with bit 7 set restarts the voice. The active flag is 1 and the waveform step is 0 two clock edges after the write is sampled. The restart uses the register values written up to and including that write.
- R4: A 3-bit timebase counter advances on every tick pulse. A tick taken while the counter is even clocks the duration counter. A tick taken at 2 or 6 clocks the sweep. A tick taken at 7 clocks the volume ramp. The counter starts at 0 after reset.
- R5: Register 0 holds the sweep period in bits 6:4, the direction in bit 3 (0 adds, 1 subtracts) and the shift n in bits 2:0. Every period sweep events the frequency becomes F plus or minus (F shifted right by n). The count is re-armed at restart.
- R6: A sweep step whose sum exceeds 2047 leaves F unchanged and clears the active flag.
- R7: A sweep period of 0 never changes the frequency.
- R8: Register 2 holds the initial volume in bits 7:4, the ramp direction in bit 3 (1 up, 0 down) and the ramp period p in bits 2:0. At restart the volume loads the initial value. Every p ramp events it moves by one, and it stays at 15 going up and at 0 going down.
- R9: A ramp period of 0 keeps the volume at its restart value.
- R10: A write to register 1 loads the duration counter with 64 minus bits 5:0. When bit 6 of register 4 (stop enable) is set, each duration event decrements the counter, and reaching 0 clears the active flag. When it is clear, duration events do not affect the flag.
- R11: A restart finding the duration counter at 0 reloads it with 64.
- R12: After reset the active flag and the amplitude are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the waveform timebase |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index 0 to 4 |
| wr_data | input | 8 | Write data |
| seq_tick | input | 1 | One-cycle pulse from the slow timebase |
| amp | output | 4 | Digital amplitude sample |
| active | output | 1 | Voice is sounding |

## Verification
A wrong waveform step count or divider reload value shows up within one output period as a wrong high-cycle count or a wrong spacing between rising edges. A sweep computed wrongly shows in the next period as a pitch other than the one the bench computes, or as an active flag that drops when it should not. Ramp and duration errors show on the timebase tick where the step is due, as a wrong peak amplitude or an active flag that changes one event early or late.

// File: rtl/sq_voice_pkg.sv
// Shared constants for the square-wave voice.
// Assumes an 8-step waveform and the fixed register numbering below.
package sq_voice_pkg;
    typedef enum logic [2:0] {
        REG_SWEEP = 3'd0,
        REG_SHAPE = 3'd1,
        REG_RAMP  = 3'd2,
        REG_FLO   = 3'd3,
        REG_FHI   = 3'd4
    } reg_sel_e;

    localparam int WAVE_STEPS = 8;

    // Level of waveform step 'step' for duty code 'code': the high steps come last.
    function automatic logic duty_level(input logic [1:0] code, input logic [2:0] step);
        int high_cnt;
        case (code)
            2'd0:    high_cnt = 1;
            2'd1:    high_cnt = 2;
            2'd2:    high_cnt = 4;
            default: high_cnt = 6;
        endcase
        return int'(step) >= (WAVE_STEPS - high_cnt);
    endfunction
endpackage

// File: rtl/sq_voice_wave.sv
// Waveform divider and step counter.
// Assumes freq is stable except at register writes or sweep steps; trig restarts at step 0.
module sq_voice_wave #(
    parameter int FREQ_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [FREQ_W-1:0] freq,
    input  logic [1:0]        duty,
    output logic              level
);
    import sq_voice_pkg::*;
    localparam int CNT_W = FREQ_W + 1;
    localparam logic [CNT_W-1:0] SPAN = CNT_W'(1) << FREQ_W;

    logic [CNT_W-1:0] cnt;
    logic [2:0]       step;
    logic [CNT_W-1:0] reload;

    // Reload value: core cycles per waveform step.
    always_comb reload = SPAN - {1'b0, freq};

    // Divider countdown and step advance on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            step <= '0;
        end else if (trig) begin
            cnt  <= reload;
            step <= '0;
        end else if (cnt <= CNT_W'(1)) begin
            cnt  <= reload;
            step <= step + 3'd1;
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Waveform level for the current step.
    always_comb level = duty_level(duty, step);

    // R2
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> (step == $past(step)) || (step == $past(step) + 3'd1));
endmodule

// File: rtl/sq_voice_sweep.sv
// Frequency register with exponential sweep and overflow detection.
// Assumes cfg = {period[2:0], dir, shift[2:0]}; a restart re-arms the period count.
module sq_voice_sweep #(
    parameter int FREQ_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    input  logic [6:0]        cfg,
    input  logic              trig,
    input  logic              tick,
    output logic [FREQ_W-1:0] freq,
    output logic              ovf
);
    logic [2:0]        per;
    logic              dir_sub;
    logic [2:0]        sh;
    logic [2:0]        timer;
    logic [FREQ_W-1:0] delta;
    logic [FREQ_W:0]   sum;
    logic              fire;

    // Field split and next-frequency arithmetic.
    always_comb begin
        per     = cfg[6:4];
        dir_sub = cfg[3];
        sh      = cfg[2:0];
        delta   = freq >> sh;
        sum     = dir_sub ? ({1'b0, freq} - {1'b0, delta}) : ({1'b0, freq} + {1'b0, delta});
        fire    = tick && !trig && (timer <= 3'd1) && (per != 3'd0);
        ovf     = fire && sum[FREQ_W];
    end

    // Sweep period countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timer <= '0;
        else if (trig)
            timer <= per;
        else if (tick)
            timer <= (timer <= 3'd1) ? per : timer - 3'd1;
    end

    // Frequency register: software writes take precedence over a sweep step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq <= '0;
        end else begin
            if (wr_lo)
                freq[7:0] <= wr_data;
            if (wr_hi)
                freq[FREQ_W-1:8] <= wr_data[FREQ_W-9:0];
            if (fire && !sum[FREQ_W] && !wr_lo && !wr_hi)
                freq <= sum[FREQ_W-1:0];
        end
    end

    // R5
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick || wr_lo || wr_hi) |=> $stable(freq));
    // R7
    per_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cfg[6:4] == 3'd0) && !wr_lo && !wr_hi) |=> $stable(freq));
endmodule

// File: rtl/sq_voice_ramp.sv
// Linear volume ramp with saturation.
// Assumes cfg = {init[3:0], up, period[2:0]}; changes only at restart or ramp events.
module sq_voice_ramp #(
    parameter int VOL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg,
    input  logic             trig,
    input  logic             tick,
    output logic [VOL_W-1:0] vol
);
    localparam logic [VOL_W-1:0] VMAX = '1;
    logic [2:0] timer;
    logic [2:0] per;
    logic       up;

    // Field split.
    always_comb begin
        per = cfg[2:0];
        up  = cfg[3];
    end

    // Volume load at restart and saturating step every per events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol   <= '0;
            timer <= '0;
        end else if (trig) begin
            vol   <= cfg[7:8-VOL_W];
            timer <= per;
        end else if (tick && per != 3'd0) begin
            if (timer <= 3'd1) begin
                timer <= per;
                if (up && vol != VMAX)
                    vol <= vol + 1'b1;
                else if (!up && vol != '0)
                    vol <= vol - 1'b1;
            end else begin
                timer <= timer - 3'd1;
            end
        end
    end

    // R8
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick || trig) |=> $stable(vol));
    // R9
    ramp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !trig && cfg[2:0] == 3'd0) |=> $stable(vol));
endmodule

// File: rtl/sq_voice_len.sv
// Duration counter that signals expiry when it reaches zero.
// Assumes load writes win over restart, which wins over a count event.
module sq_voice_len #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             trig,
    input  logic             en,
    input  logic             tick,
    output logic             expire
);
    localparam int CW = LEN_W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << LEN_W;
    logic [CW-1:0] cnt;

    // Expiry pulse when the last unit is counted off.
    always_comb expire = tick && en && !load && !trig && (cnt == CW'(1));

    // Counter load, restart reload and decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= FULL - {1'b0, load_val};
        else if (trig) begin
            if (cnt == '0)
                cnt <= FULL;
        end else if (tick && en && cnt != '0)
            cnt <= cnt - CW'(1);
    end

    // R10
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    // R11
    len_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !load && cnt == '0) |=> (cnt == FULL));
endmodule

// File: rtl/sq_sweep_voice.sv
// Square-wave voice top: register file, timebase sequencer, restart and active flag.
// Assumes one register write per cycle and seq_tick as a single-cycle pulse.
module sq_sweep_voice #(
    parameter int FREQ_W = 11,
    parameter int VOL_W  = 4,
    parameter int LEN_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             seq_tick,
    output logic [VOL_W-1:0] amp,
    output logic             active
);
    import sq_voice_pkg::*;

    logic [6:0]        sweep_cfg;
    logic [1:0]        duty;
    logic [7:0]        ramp_cfg;
    logic              len_en;
    logic              trig_q;
    logic [2:0]        seq_pos;
    logic              len_evt, swp_evt, ramp_evt;
    logic              wr_sweep, wr_shape, wr_ramp, wr_flo, wr_fhi;
    logic [FREQ_W-1:0] freq;
    logic              sw_ovf, len_exp, level;
    logic [VOL_W-1:0]  vol;

    // Register select decode.
    always_comb begin
        wr_sweep = wr_en && wr_addr == REG_SWEEP;
        wr_shape = wr_en && wr_addr == REG_SHAPE;
        wr_ramp  = wr_en && wr_addr == REG_RAMP;
        wr_flo   = wr_en && wr_addr == REG_FLO;
        wr_fhi   = wr_en && wr_addr == REG_FHI;
    end

    // Control registers and the delayed restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_cfg <= '0;
            duty      <= '0;
            ramp_cfg  <= '0;
            len_en    <= 1'b0;
            trig_q    <= 1'b0;
        end else begin
            if (wr_sweep) sweep_cfg <= wr_data[6:0];
            if (wr_shape) duty      <= wr_data[7:6];
            if (wr_ramp)  ramp_cfg  <= wr_data;
            if (wr_fhi)   len_en    <= wr_data[6];
            trig_q <= wr_fhi && wr_data[7];
        end
    end

    // Timebase sequencer position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_pos <= '0;
        else if (seq_tick)
            seq_pos <= seq_pos + 3'd1;
    end

    // Event decode from the position before the advance.
    always_comb begin
        len_evt  = seq_tick && !seq_pos[0];
        swp_evt  = seq_tick && (seq_pos == 3'd2 || seq_pos == 3'd6);
        ramp_evt = seq_tick && (seq_pos == 3'd7);
    end

    // Active flag: set by restart, cleared by expiry or sweep overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (trig_q)
            active <= 1'b1;
        else if (len_exp || sw_ovf)
            active <= 1'b0;
    end

    sq_voice_sweep #(.FREQ_W(FREQ_W)) u_sweep (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_flo), .wr_hi(wr_fhi), .wr_data(wr_data),
        .cfg(sweep_cfg), .trig(trig_q), .tick(swp_evt), .freq(freq), .ovf(sw_ovf)
    );

    sq_voice_wave #(.FREQ_W(FREQ_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .trig(trig_q), .freq(freq), .duty(duty), .level(level)
    );

    sq_voice_ramp #(.VOL_W(VOL_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .cfg(ramp_cfg), .trig(trig_q), .tick(ramp_evt), .vol(vol)
    );

    sq_voice_len #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .load(wr_shape), .load_val(wr_data[LEN_W-1:0]),
        .trig(trig_q), .en(len_en), .tick(len_evt), .expire(len_exp)
    );

    // Output sample.
    always_comb amp = (active && level) ? vol : '0;

    // R6
    ovf_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ovf && !trig_q) |=> !active);
    // R3
    restart_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> active);
endmodule

// File: tb/sim_sq_sweep_voice.sv
`timescale 1ns/1ps
module sim_sq_sweep_voice;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       seq_tick = 1'b0;
    logic [3:0] amp;
    logic       active;

    int checks = 0;
    int errors = 0;
    int fs = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sq_sweep_voice u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .seq_tick(seq_tick), .amp(amp), .active(active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Restart: frequency written, then restart write, then let it take hold.
    task automatic restart(input int f, input bit len_on);
        wr(3'd3, 8'(f));
        wr(3'd4, {1'b1, len_on, 3'b000, 3'(f >> 8)});
        @(negedge clk);
        @(negedge clk);
    endtask

    // One timebase pulse; kind 0 duration, 1 sweep, 2 ramp: loops until that event.
    task automatic run_until(input int kind);
        bit hit;
        hit = 0;
        while (!hit) begin
            case (kind)
                0: hit = (fs % 2 == 0);
                1: hit = (fs == 2 || fs == 6);
                default: hit = (fs == 7);
            endcase
            @(negedge clk);
            seq_tick = 1'b1;
            @(negedge clk);
            seq_tick = 1'b0;
            fs = (fs + 1) % 8;
        end
    endtask

    // Cycles between two rising edges of the amplitude; -1 on timeout.
    task automatic period(output int p);
        int n;
        n = 0;
        p = -1;
        while (amp != 0 && n < 20000) begin @(negedge clk); n++; end
        while (amp == 0 && n < 20000) begin @(negedge clk); n++; end
        p = 0;
        while (amp != 0 && n < 40000) begin @(negedge clk); n++; p++; end
        while (amp == 0 && n < 40000) begin @(negedge clk); n++; p++; end
        if (n >= 40000) p = -1;
    endtask

    task automatic peak(output int m);
        m = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (int'(amp) > m) m = int'(amp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p, m, hi, sum, nf, expv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(active == 1'b0, "R12 active", int'(active), 0);
        chk(amp == 4'd0, "R12 amp", int'(amp), 0);

        // R1 duty codes, F=2047 gives one cycle per step
        wr(3'd2, 8'hF0);
        for (int d = 0; d < 4; d++) begin
            wr(3'd1, {2'(d), 6'd0});
            restart(2047, 1'b0);
            // R3 restart turns the voice on
            chk(active == 1'b1, "R3 active after restart", int'(active), 1);
            hi = 0; sum = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (amp != 0) hi++;
                sum += int'(amp);
            end
            expv = (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 4 : 6;
            chk(hi == expv, "R1 high steps", hi, expv);
            chk(sum == 15 * expv, "R1 amplitude", sum, 15 * expv);
        end

        // R2 period sweep over the top of the frequency range
        wr(3'd1, 8'h80);
        for (int f = 2040; f < 2048; f++) begin
            restart(f, 1'b0);
            period(p);
            chk(p == 8 * (2048 - f), "R2 period", p, 8 * (2048 - f));
        end

        // R5 R6 additive sweep, period 1, every shift
        for (int n = 0; n < 8; n++) begin
            wr(3'd0, {1'b0, 3'd1, 1'b0, 3'(n)});
            restart(1984, 1'b0);
            run_until(1); // R4 sweep on positions 2 and 6
            nf = 1984 + (1984 >> n);
            if (nf > 2047) begin
                @(negedge clk);
                chk(active == 1'b0, "R6 overflow silences", int'(active), 0);
            end else begin
                chk(active == 1'b1, "R5 no overflow", int'(active), 1);
                period(p);
                chk(p == 8 * (2048 - nf), "R5 add sweep", p, 8 * (2048 - nf));
            end
        end

        // R5 subtractive sweep
        for (int n = 3; n < 8; n++) begin
            wr(3'd0, {1'b0, 3'd1, 1'b1, 3'(n)});
            restart(1984, 1'b0);
            run_until(1);
            nf = 1984 - (1984 >> n);
            period(p);
            chk(p == 8 * (2048 - nf), "R5 sub sweep", p, 8 * (2048 - nf));
        end

        // R5 sweep period 2: first event leaves F, second applies
        wr(3'd0, {1'b0, 3'd2, 1'b0, 3'd5});
        restart(1984, 1'b0);
        run_until(1);
        period(p);
        chk(p == 512, "R5 period two first event", p, 512);
        run_until(1);
        period(p);
        chk(p == 16, "R5 period two second event", p, 16);

        // R7 sweep period 0 holds F even where the step would overflow
        wr(3'd0, {1'b0, 3'd0, 1'b0, 3'd1});
        restart(1984, 1'b0);
        run_until(1);
        run_until(1);
        chk(active == 1'b1, "R7 still active", int'(active), 1);
        period(p);
        chk(p == 512, "R7 frequency held", p, 512);

        // R8 ramp up from 0, period 1, saturating at 15
        wr(3'd1, 8'hC0);
        wr(3'd2, 8'h09);
        restart(2047, 1'b0);
        for (int k = 1; k <= 17; k++) begin
            run_until(2); // R4 ramp on position 7
            peak(m);
            expv = (k > 15) ? 15 : k;
            chk(m == expv, "R8 ramp up", m, expv);
        end

        // R8 ramp down from 15, period 2, saturating at 0
        wr(3'd2, 8'hF2);
        restart(2047, 1'b0);
        for (int k = 1; k <= 32; k++) begin
            run_until(2);
            peak(m);
            expv = 15 - k / 2;
            if (expv < 0) expv = 0;
            chk(m == expv, "R8 ramp down", m, expv);
        end

        // R9 ramp period 0 keeps the restart volume
        wr(3'd2, 8'h98);
        restart(2047, 1'b0);
        for (int k = 0; k < 3; k++) run_until(2);
        peak(m);
        chk(m == 9, "R9 volume held", m, 9);

        // R10 duration 64-60=4 events with stop enabled
        wr(3'd2, 8'hF0);
        wr(3'd1, {2'd3, 6'd60});
        restart(2047, 1'b1);
        for (int k = 0; k < 3; k++) run_until(0);
        chk(active == 1'b1, "R10 before expiry", int'(active), 1);
        run_until(0);
        chk(active == 1'b0, "R10 expiry", int'(active), 0);
        peak(m);
        chk(m == 0, "R10 silent after expiry", m, 0);

        // R11 restart with counter at 0 reloads 64
        restart(2047, 1'b1);
        chk(active == 1'b1, "R3 restart after expiry", int'(active), 1);
        for (int k = 0; k < 63; k++) run_until(0);
        chk(active == 1'b1, "R11 after 63 events", int'(active), 1);
        run_until(0);
        chk(active == 1'b0, "R11 after 64 events", int'(active), 0);

        // R10 stop disabled: duration events have no effect
        wr(3'd1, {2'd3, 6'd63});
        restart(2047, 1'b0);
        for (int k = 0; k < 10; k++) run_until(0);
        chk(active == 1'b1, "R10 stop disabled", int'(active), 1);
        peak(m);
        chk(m == 15, "R10 output kept", m, 15);
        wr(3'd4, 8'h47);
        run_until(0);
        chk(active == 1'b0, "R10 enable without restart", int'(active), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule